// File: doc/BRIEF.md
# Decimator Configuration Register Bank

This block is the software-visible control store for a two-channel sample decimation chain. A processor reaches it through an AXI4-Lite slave port. It keeps the settings that steer the chain: how many output samples to drop, which filtered reduction ratio to apply, whether each channel's gain correction is on, and the two correction coefficients. It also holds a read-only identification word and a free scratch word for software.

Every stored setting is driven straight out as a configuration port into the sample logic, which shares the bus clock. The block also produces two status outputs from the stored ratio code. The first is a 3-bit rate code that mirrors the stored code. The second is a flag that is high when that code selects a real filtered reduction.

Writes honour byte strobes. The write address and the write data may arrive in any order. The bus never receives an error: unmapped reads return zero and unmapped or read-only writes are dropped.

Top module: `dec_ctrl_regs`

## Requirements
- R1: After synchronous reset the drop ratio output is 1, the ratio code is 0, both correction enables are 0, both coefficients are 0x4000, the oversampling flag is 0, and the scratch word reads 0.
- R2: Byte address 0x00 reads the VERSION parameter (default 0x00020100), and a write to it leaves the value read back unchanged.
- R3: Byte address 0x04 is a 32-bit scratch word that reads back the last value written.
- R4: Byte address 0x40 holds the 32-bit drop ratio, driven on `cfg_drop_ratio` and readable.
- R5: Bits [2:0] of byte address 0x44 hold the ratio code, and bits above it read as zero. `data_rate` equals the stored code. `ovs_en` is 1 for codes 1, 2, 3, 6 and 7 and 0 for codes 0, 4 and 5.
- R6: At byte address 0x48, bit 0 drives `cfg_corr_en[0]` (channel A) and bit 1 drives `cfg_corr_en[1]` (channel B).
- R7: The 16-bit channel A coefficient is at byte address 0x4C and the channel B coefficient is at 0x50, each in bits [15:0]. Upper bits are not stored and read as zero.
- R8: A write changes only the byte lanes whose `s_axi_wstrb` bit is 1.
- R9: Write address and write data are each accepted on their own handshake, in either order. The response (`bresp` = 2'b00) is raised only after both are accepted, and the configuration outputs change only in the cycle the response is raised.
- R10: A read of any unmapped address returns 0 with `rresp` = 2'b00. A write to an unmapped address gets `bresp` = 2'b00 and changes no output.
- R11: `bvalid` and `rvalid` stay high with `rdata` stable until the matching ready. While a response is pending, the corresponding address (and write data) ready stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared bus and sample clock |
| rst | input | 1 | Synchronous reset, active high |
| s_axi_awaddr | input | ADDR_W | Write byte address |
| s_axi_awvalid | input | 1 | Write address valid |
| s_axi_awready | output | 1 | Write address ready |
| s_axi_wdata | input | DATA_W | Write data |
| s_axi_wstrb | input | DATA_W/8 | Write byte strobes |
| s_axi_wvalid | input | 1 | Write data valid |
| s_axi_wready | output | 1 | Write data ready |
| s_axi_bresp | output | 2 | Write response, always OKAY |
| s_axi_bvalid | output | 1 | Write response valid |
| s_axi_bready | input | 1 | Write response ready |
| s_axi_araddr | input | ADDR_W | Read byte address |
| s_axi_arvalid | input | 1 | Read address valid |
| s_axi_arready | output | 1 | Read address ready |
| s_axi_rdata | output | DATA_W | Read data |
| s_axi_rresp | output | 2 | Read response, always OKAY |
| s_axi_rvalid | output | 1 | Read data valid |
| s_axi_rready | input | 1 | Read data ready |
| cfg_drop_ratio | output | DATA_W | Sample drop ratio |
| cfg_filt_code | output | 3 | Filtered ratio code |
| cfg_corr_en | output | 2 | Correction enables, bit 0 channel A, bit 1 channel B |
| cfg_coef_a | output | COEF_W | Channel A correction coefficient |
| cfg_coef_b | output | COEF_W | Channel B correction coefficient |
| data_rate | output | 3 | Rate code, mirror of the stored ratio code |
| ovs_en | output | 1 | High when the code selects a filtered ratio |

## Verification
The hardest situation to reach is a write whose address and data halves are separated in time. One half sits held inside the block while the other has not yet arrived, and the response must stay low during that gap. The write task can present the address first or the data first, and it waits several idle cycles before offering the second half. During that gap it checks that no response and no configuration change appears. The stimulus also holds `bready` and `rready` low for several cycles to reach the pending-response state, where the ready signals must stay low and the read data must stay stable.

// File: rtl/dec_ctrl_pkg.sv
package dec_ctrl_pkg;

   typedef enum logic [1:0] {
      RESP_OKAY   = 2'b00,
      RESP_SLVERR = 2'b10
   } axi_resp_e;

   localparam int unsigned CODE_W = 3;
   localparam int unsigned NCH    = 2;

   // word indices (byte address / 4)
   localparam int unsigned WIX_IDENT  = 0;
   localparam int unsigned WIX_SCRTCH = 1;
   localparam int unsigned WIX_DROP   = 16;
   localparam int unsigned WIX_CODE   = 17;
   localparam int unsigned WIX_CORR   = 18;
   localparam int unsigned WIX_COEF_A = 19;
   localparam int unsigned WIX_COEF_B = 20;

   // codes 1,2,3,6,7 select a filtered reduction
   function automatic logic code_is_filtered(input logic [CODE_W-1:0] c);
      case (c)
         3'd1, 3'd2, 3'd3, 3'd6, 3'd7: code_is_filtered = 1'b1;
         default:                      code_is_filtered = 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/dec_ctrl_wr_chan.sv
module dec_ctrl_wr_chan #(
   parameter int unsigned IX_W   = 6,
   parameter int unsigned DATA_W = 32,
   localparam int unsigned STRB_W = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [IX_W-1:0]   aw_ix,
   input  logic              awvalid,
   output logic              awready,
   input  logic [DATA_W-1:0] wdata,
   input  logic [STRB_W-1:0] wstrb,
   input  logic              wvalid,
   output logic              wready,
   output logic [1:0]        bresp,
   output logic              bvalid,
   input  logic              bready,
   output logic              wr_en,
   output logic [IX_W-1:0]   wr_ix,
   output logic [DATA_W-1:0] wr_data,
   output logic [STRB_W-1:0] wr_strb
);
   import dec_ctrl_pkg::*;

   logic aw_held, w_held, bvalid_q;

   assign awready = !aw_held && !bvalid_q;
   assign wready  = !w_held && !bvalid_q;
   assign wr_en   = aw_held && w_held && !bvalid_q;
   assign bvalid  = bvalid_q;
   assign bresp   = RESP_OKAY;

   always_ff @(posedge clk) begin
      if (rst) begin
         aw_held  <= 1'b0;
         w_held   <= 1'b0;
         bvalid_q <= 1'b0;
         wr_ix    <= '0;
         wr_data  <= '0;
         wr_strb  <= '0;
      end else begin
         if (awvalid && awready) begin
            aw_held <= 1'b1;
            wr_ix   <= aw_ix;
         end
         if (wvalid && wready) begin
            w_held  <= 1'b1;
            wr_data <= wdata;
            wr_strb <= wstrb;
         end
         if (wr_en) begin
            aw_held  <= 1'b0;
            w_held   <= 1'b0;
            bvalid_q <= 1'b1;
         end else if (bvalid_q && bready) begin
            bvalid_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/dec_ctrl_rd_chan.sv
module dec_ctrl_rd_chan #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              arvalid,
   output logic              arready,
   output logic [DATA_W-1:0] rdata,
   output logic [1:0]        rresp,
   output logic              rvalid,
   input  logic              rready,
   input  logic [DATA_W-1:0] rd_word
);
   import dec_ctrl_pkg::*;

   logic rvalid_q;

   assign arready = !rvalid_q;
   assign rvalid  = rvalid_q;
   assign rresp   = RESP_OKAY;

   always_ff @(posedge clk) begin
      if (rst) begin
         rvalid_q <= 1'b0;
         rdata    <= '0;
      end else if (arvalid && arready) begin
         rvalid_q <= 1'b1;
         rdata    <= rd_word;
      end else if (rvalid_q && rready) begin
         rvalid_q <= 1'b0;
      end
   end

endmodule

// File: rtl/dec_ctrl_regfile.sv
module dec_ctrl_regfile #(
   parameter int unsigned    IX_W     = 6,
   parameter int unsigned    DATA_W   = 32,
   parameter int unsigned    COEF_W   = 16,
   parameter bit             USE_STRB = 1'b1,
   parameter logic [31:0]    VERSION  = 32'h0002_0100,
   localparam int unsigned   STRB_W   = DATA_W / 8,
   localparam int unsigned   CODE_W   = dec_ctrl_pkg::CODE_W,
   localparam int unsigned   NCH      = dec_ctrl_pkg::NCH
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [IX_W-1:0]   wr_ix,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [STRB_W-1:0] wr_strb,
   input  logic [IX_W-1:0]   rd_ix,
   output logic [DATA_W-1:0] rd_word,
   output logic [DATA_W-1:0] drop_q,
   output logic [CODE_W-1:0] code_q,
   output logic [NCH-1:0]    corr_q,
   output logic [COEF_W-1:0] coef_a_q,
   output logic [COEF_W-1:0] coef_b_q,
   output logic              ovs_q
);
   import dec_ctrl_pkg::*;

   localparam logic [COEF_W-1:0] COEF_ONE = COEF_W'(1) << (COEF_W - 2);

   logic [DATA_W-1:0] scratch_q;
   logic [STRB_W-1:0] lane;

   generate
      if (USE_STRB) begin : g_strb
         assign lane = wr_strb;
      end else begin : g_full
         logic unused_strb;
         assign unused_strb = ^wr_strb;
         assign lane = '1;
      end
   endgenerate

   function automatic logic [DATA_W-1:0] mrg_word(input logic [DATA_W-1:0] old);
      logic [DATA_W-1:0] r;
      for (int i = 0; i < DATA_W; i++) r[i] = lane[i/8] ? wr_data[i] : old[i];
      return r;
   endfunction

   function automatic logic [COEF_W-1:0] mrg_coef(input logic [COEF_W-1:0] old);
      logic [COEF_W-1:0] r;
      for (int i = 0; i < COEF_W; i++) r[i] = lane[i/8] ? wr_data[i] : old[i];
      return r;
   endfunction

   logic [CODE_W-1:0] code_nx;
   assign code_nx = lane[0] ? wr_data[CODE_W-1:0] : code_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         scratch_q <= '0;
         drop_q    <= DATA_W'(1);
         code_q    <= '0;
         ovs_q     <= 1'b0;
         corr_q    <= '0;
         coef_a_q  <= COEF_ONE;
         coef_b_q  <= COEF_ONE;
      end else if (wr_en) begin
         case (int'(wr_ix))
            WIX_SCRTCH: scratch_q <= mrg_word(scratch_q);
            WIX_DROP:   drop_q    <= mrg_word(drop_q);
            WIX_CODE: begin
               code_q <= code_nx;
               ovs_q  <= code_is_filtered(code_nx);
            end
            WIX_CORR:   if (lane[0]) corr_q <= wr_data[NCH-1:0];
            WIX_COEF_A: coef_a_q <= mrg_coef(coef_a_q);
            WIX_COEF_B: coef_b_q <= mrg_coef(coef_b_q);
            default: ;
         endcase
      end
   end

   always_comb begin
      rd_word = '0;
      case (int'(rd_ix))
         WIX_IDENT:  rd_word = DATA_W'(VERSION);
         WIX_SCRTCH: rd_word = scratch_q;
         WIX_DROP:   rd_word = drop_q;
         WIX_CODE:   rd_word = DATA_W'(code_q);
         WIX_CORR:   rd_word = DATA_W'(corr_q);
         WIX_COEF_A: rd_word = DATA_W'(coef_a_q);
         WIX_COEF_B: rd_word = DATA_W'(coef_b_q);
         default:    rd_word = '0;
      endcase
   end

endmodule

// File: rtl/dec_ctrl_regs.sv
module dec_ctrl_regs #(
   parameter int unsigned  ADDR_W   = 8,
   parameter int unsigned  DATA_W   = 32,
   parameter int unsigned  COEF_W   = 16,
   parameter bit           USE_STRB = 1'b1,
   parameter logic [31:0]  VERSION  = 32'h0002_0100,
   localparam int unsigned STRB_W   = DATA_W / 8,
   localparam int unsigned IX_W     = ADDR_W - 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] s_axi_awaddr,
   input  logic              s_axi_awvalid,
   output logic              s_axi_awready,
   input  logic [DATA_W-1:0] s_axi_wdata,
   input  logic [STRB_W-1:0] s_axi_wstrb,
   input  logic              s_axi_wvalid,
   output logic              s_axi_wready,
   output logic [1:0]        s_axi_bresp,
   output logic              s_axi_bvalid,
   input  logic              s_axi_bready,
   input  logic [ADDR_W-1:0] s_axi_araddr,
   input  logic              s_axi_arvalid,
   output logic              s_axi_arready,
   output logic [DATA_W-1:0] s_axi_rdata,
   output logic [1:0]        s_axi_rresp,
   output logic              s_axi_rvalid,
   input  logic              s_axi_rready,
   output logic [DATA_W-1:0] cfg_drop_ratio,
   output logic [2:0]        cfg_filt_code,
   output logic [1:0]        cfg_corr_en,
   output logic [COEF_W-1:0] cfg_coef_a,
   output logic [COEF_W-1:0] cfg_coef_b,
   output logic [2:0]        data_rate,
   output logic              ovs_en
);
   // elaboration-time parameter checks
   if (DATA_W != 32) begin : g_bad_data_w
      $error("dec_ctrl_regs: DATA_W must be 32");
   end
   if (ADDR_W < 7) begin : g_bad_addr_w
      $error("dec_ctrl_regs: ADDR_W must reach byte offset 0x50");
   end
   if (COEF_W < 2 || COEF_W > DATA_W) begin : g_bad_coef_w
      $error("dec_ctrl_regs: COEF_W out of range");
   end

   logic              unused_lsb;
   logic              wr_en;
   logic [IX_W-1:0]   wr_ix;
   logic [DATA_W-1:0] wr_data;
   logic [STRB_W-1:0] wr_strb;
   logic [DATA_W-1:0] rd_word;

   assign unused_lsb = ^{s_axi_awaddr[1:0], s_axi_araddr[1:0]};

   dec_ctrl_wr_chan #(.IX_W(IX_W), .DATA_W(DATA_W)) i_wr (
      .clk     (clk),
      .rst     (rst),
      .aw_ix   (s_axi_awaddr[ADDR_W-1:2]),
      .awvalid (s_axi_awvalid),
      .awready (s_axi_awready),
      .wdata   (s_axi_wdata),
      .wstrb   (s_axi_wstrb),
      .wvalid  (s_axi_wvalid),
      .wready  (s_axi_wready),
      .bresp   (s_axi_bresp),
      .bvalid  (s_axi_bvalid),
      .bready  (s_axi_bready),
      .wr_en   (wr_en),
      .wr_ix   (wr_ix),
      .wr_data (wr_data),
      .wr_strb (wr_strb)
   );

   dec_ctrl_rd_chan #(.DATA_W(DATA_W)) i_rd (
      .clk     (clk),
      .rst     (rst),
      .arvalid (s_axi_arvalid),
      .arready (s_axi_arready),
      .rdata   (s_axi_rdata),
      .rresp   (s_axi_rresp),
      .rvalid  (s_axi_rvalid),
      .rready  (s_axi_rready),
      .rd_word (rd_word)
   );

   dec_ctrl_regfile #(
      .IX_W(IX_W), .DATA_W(DATA_W), .COEF_W(COEF_W),
      .USE_STRB(USE_STRB), .VERSION(VERSION)
   ) i_rf (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_en),
      .wr_ix    (wr_ix),
      .wr_data  (wr_data),
      .wr_strb  (wr_strb),
      .rd_ix    (s_axi_araddr[ADDR_W-1:2]),
      .rd_word  (rd_word),
      .drop_q   (cfg_drop_ratio),
      .code_q   (cfg_filt_code),
      .corr_q   (cfg_corr_en),
      .coef_a_q (cfg_coef_a),
      .coef_b_q (cfg_coef_b),
      .ovs_q    (ovs_en)
   );

   assign data_rate = cfg_filt_code;

endmodule

// File: rtl/dec_ctrl_regs_chk.sv
module dec_ctrl_regs_chk #(
   parameter int unsigned  ADDR_W = 8,
   parameter int unsigned  DATA_W = 32,
   parameter int unsigned  COEF_W = 16,
   localparam int unsigned STRB_W = DATA_W / 8
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] s_axi_awaddr,
   input logic              s_axi_awvalid,
   input logic              s_axi_awready,
   input logic [DATA_W-1:0] s_axi_wdata,
   input logic [STRB_W-1:0] s_axi_wstrb,
   input logic              s_axi_wvalid,
   input logic              s_axi_wready,
   input logic [1:0]        s_axi_bresp,
   input logic              s_axi_bvalid,
   input logic              s_axi_bready,
   input logic [ADDR_W-1:0] s_axi_araddr,
   input logic              s_axi_arvalid,
   input logic              s_axi_arready,
   input logic [DATA_W-1:0] s_axi_rdata,
   input logic [1:0]        s_axi_rresp,
   input logic              s_axi_rvalid,
   input logic              s_axi_rready,
   input logic [DATA_W-1:0] cfg_drop_ratio,
   input logic [2:0]        cfg_filt_code,
   input logic [1:0]        cfg_corr_en,
   input logic [COEF_W-1:0] cfg_coef_a,
   input logic [COEF_W-1:0] cfg_coef_b,
   input logic [2:0]        data_rate,
   input logic              ovs_en
);
   localparam logic [COEF_W-1:0] ONE = COEF_W'(1) << (COEF_W - 2);

   p_reset_vals_r1: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (cfg_drop_ratio == DATA_W'(1)) && (cfg_filt_code == 3'd0) &&
                     (cfg_corr_en == 2'b00) && (cfg_coef_a == ONE) &&
                     (cfg_coef_b == ONE) && !ovs_en);

   p_ovs_matches_rate_r5: assert property (@(posedge clk) disable iff (rst)
      ovs_en == (data_rate inside {3'd1, 3'd2, 3'd3, 3'd6, 3'd7}));

   p_rate_mirror_r5: assert property (@(posedge clk) disable iff (rst)
      data_rate == cfg_filt_code);

   p_bresp_okay_r9: assert property (@(posedge clk) disable iff (rst)
      s_axi_bvalid |-> s_axi_bresp == 2'b00);

   p_resp_after_both_r9: assert property (@(posedge clk) disable iff (rst)
      $rose(s_axi_bvalid) |-> !$past(s_axi_awready) && !$past(s_axi_wready));

   p_cfg_change_on_commit_r9: assert property (@(posedge clk) disable iff (rst)
      !$rose(s_axi_bvalid) |-> $stable(cfg_drop_ratio) && $stable(cfg_filt_code) &&
                               $stable(cfg_corr_en) && $stable(cfg_coef_a) &&
                               $stable(cfg_coef_b) && $stable(ovs_en));

   p_rresp_okay_r10: assert property (@(posedge clk) disable iff (rst)
      s_axi_rvalid |-> s_axi_rresp == 2'b00);

   p_bvalid_hold_r11: assert property (@(posedge clk) disable iff (rst)
      s_axi_bvalid && !s_axi_bready |=> s_axi_bvalid);

   p_rvalid_hold_r11: assert property (@(posedge clk) disable iff (rst)
      s_axi_rvalid && !s_axi_rready |=> s_axi_rvalid && $stable(s_axi_rdata));

   p_no_accept_pending_r11: assert property (@(posedge clk) disable iff (rst)
      s_axi_bvalid |-> !s_axi_awready && !s_axi_wready);

   p_no_ar_pending_r11: assert property (@(posedge clk) disable iff (rst)
      s_axi_rvalid |-> !s_axi_arready);

endmodule

bind dec_ctrl_regs dec_ctrl_regs_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .COEF_W(COEF_W)
) i_chk (.*);

// File: tb/test_dec_ctrl_regs.sv
module test_dec_ctrl_regs;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  awaddr = '0, araddr = '0;
   logic        awvalid = 1'b0, wvalid = 1'b0, bready = 1'b0;
   logic        arvalid = 1'b0, rready = 1'b0;
   logic [31:0] wdata = '0;
   logic [3:0]  wstrb = '0;
   logic        awready, wready, bvalid, arready, rvalid, ovs_en;
   logic [1:0]  bresp, rresp, corr_en;
   logic [31:0] rdata, drop_ratio;
   logic [2:0]  filt_code, data_rate;
   logic [15:0] coef_a, coef_b;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   dec_ctrl_regs i_dec_ctrl_regs (
      .clk(clk), .rst(rst),
      .s_axi_awaddr(awaddr), .s_axi_awvalid(awvalid), .s_axi_awready(awready),
      .s_axi_wdata(wdata), .s_axi_wstrb(wstrb), .s_axi_wvalid(wvalid), .s_axi_wready(wready),
      .s_axi_bresp(bresp), .s_axi_bvalid(bvalid), .s_axi_bready(bready),
      .s_axi_araddr(araddr), .s_axi_arvalid(arvalid), .s_axi_arready(arready),
      .s_axi_rdata(rdata), .s_axi_rresp(rresp), .s_axi_rvalid(rvalid), .s_axi_rready(rready),
      .cfg_drop_ratio(drop_ratio), .cfg_filt_code(filt_code), .cfg_corr_en(corr_en),
      .cfg_coef_a(coef_a), .cfg_coef_b(coef_b), .data_rate(data_rate), .ovs_en(ovs_en)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   // order: 0 = together, 1 = address first, 2 = data first; hold = cycles bready stays low
   task automatic axi_wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s,
                         input int order, input int hold);
      bit aw_todo = 1'b1, w_todo = 1'b1, aw_go, w_go;
      @(negedge clk);
      if (order != 2) begin awaddr = a; awvalid = 1'b1; end
      if (order != 1) begin wdata = d; wstrb = s; wvalid = 1'b1; end
      while (aw_todo || w_todo) begin
         aw_go = awvalid && awready;
         w_go  = wvalid && wready;
         @(negedge clk);
         if (aw_go) begin
            awvalid = 1'b0; aw_todo = 1'b0;
            if (order == 1) begin
               for (int k = 0; k < 3; k++) begin
                  chk("R9 no response before data", 32'(bvalid), 32'd0);
                  @(negedge clk);
               end
               wdata = d; wstrb = s; wvalid = 1'b1;
            end
         end
         if (w_go) begin
            wvalid = 1'b0; w_todo = 1'b0;
            if (order == 2) begin
               for (int k = 0; k < 3; k++) begin
                  chk("R9 no response before address", 32'(bvalid), 32'd0);
                  @(negedge clk);
               end
               awaddr = a; awvalid = 1'b1;
            end
         end
      end
      while (!bvalid) @(negedge clk);
      chk("R9 bresp okay", 32'(bresp), 32'd0);
      for (int k = 0; k < hold; k++) begin
         chk("R11 bvalid held", 32'(bvalid), 32'd1);
         chk("R11 awready low while pending", 32'(awready), 32'd0);
         @(negedge clk);
      end
      bready = 1'b1;
      @(negedge clk);
      bready = 1'b0;
   endtask

   task automatic axi_rd(input logic [7:0] a, input int hold, output logic [31:0] d);
      logic [31:0] first;
      @(negedge clk);
      araddr = a; arvalid = 1'b1;
      while (!arready) @(negedge clk);
      @(negedge clk);
      arvalid = 1'b0;
      while (!rvalid) @(negedge clk);
      first = rdata;
      chk("R10 rresp okay", 32'(rresp), 32'd0);
      for (int k = 0; k < hold; k++) begin
         chk("R11 rvalid held", 32'(rvalid), 32'd1);
         chk("R11 rdata stable", rdata, first);
         chk("R11 arready low while pending", 32'(arready), 32'd0);
         @(negedge clk);
      end
      rready = 1'b1;
      @(negedge clk);
      rready = 1'b0;
      d = first;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      chk("R1 drop ratio", drop_ratio, 32'd1);
      chk("R1 code", 32'(filt_code), 32'd0);
      chk("R1 corr", 32'(corr_en), 32'd0);
      chk("R1 coef a", 32'(coef_a), 32'h4000);
      chk("R1 coef b", 32'(coef_b), 32'h4000);
      chk("R1 ovs", 32'(ovs_en), 32'd0);
      chk("R1 bvalid", 32'(bvalid), 32'd0);
      chk("R1 rvalid", 32'(rvalid), 32'd0);
      axi_rd(8'h04, 0, v); chk("R1 scratch", v, 32'd0);
      axi_rd(8'h00, 0, v); chk("R2 version", v, 32'h0002_0100);
   endtask

   task automatic t_scratch;
      logic [31:0] v;
      axi_wr(8'h04, 32'hA5A5_1234, 4'hF, 0, 0);
      axi_rd(8'h04, 0, v); chk("R3 scratch", v, 32'hA5A5_1234);
      axi_wr(8'h04, 32'h0F0F_F0F0, 4'hF, 2, 0);
      axi_rd(8'h04, 0, v); chk("R3 scratch second", v, 32'h0F0F_F0F0);
   endtask

   task automatic t_ratio;
      logic [31:0] v;
      axi_wr(8'h40, 32'h0001_86A0, 4'hF, 1, 0);
      chk("R4 drop out", drop_ratio, 32'h0001_86A0);
      axi_rd(8'h40, 0, v); chk("R4 drop read", v, 32'h0001_86A0);
   endtask

   task automatic t_codes;
      logic [31:0] v;
      for (int c = 0; c < 8; c++) begin
         logic exp_ovs;
         exp_ovs = (c == 1) || (c == 2) || (c == 3) || (c == 6) || (c == 7);
         axi_wr(8'h44, 32'hFFFF_FFF8 | 32'(c), 4'hF, 2, 0);
         chk("R5 data_rate", 32'(data_rate), 32'(c));
         chk("R5 ovs_en", 32'(ovs_en), 32'(exp_ovs));
         axi_rd(8'h44, 0, v); chk("R5 code read", v, 32'(c));
      end
   endtask

   task automatic t_config;
      logic [31:0] v;
      axi_wr(8'h48, 32'h0000_0001, 4'hF, 0, 0);
      chk("R6 chan A only", 32'(corr_en), 32'b01);
      axi_wr(8'h48, 32'h0000_0002, 4'hF, 1, 0);
      chk("R6 chan B only", 32'(corr_en), 32'b10);
      axi_rd(8'h48, 0, v); chk("R6 read", v, 32'd2);
   endtask

   task automatic t_coefs;
      logic [31:0] v;
      axi_wr(8'h4C, 32'hFFFF_8123, 4'hF, 0, 0);
      axi_wr(8'h50, 32'h1234_3FFF, 4'hF, 0, 0);
      chk("R7 coef a", 32'(coef_a), 32'h8123);
      chk("R7 coef b", 32'(coef_b), 32'h3FFF);
      axi_rd(8'h4C, 0, v); chk("R7 coef a read", v, 32'h0000_8123);
      axi_rd(8'h50, 0, v); chk("R7 coef b read", v, 32'h0000_3FFF);
   endtask

   task automatic t_strobes;
      logic [31:0] v;
      axi_wr(8'h40, 32'h1122_3344, 4'hF, 0, 0);
      axi_wr(8'h40, 32'hAABB_CCDD, 4'b0101, 0, 0);
      chk("R8 lanes 0 and 2", drop_ratio, 32'h11BB_33DD);
      axi_wr(8'h4C, 32'h0000_77EE, 4'b0010, 0, 0);
      chk("R8 coef upper lane", 32'(coef_a), 32'h7723);
      axi_wr(8'h04, 32'hFFFF_FFFF, 4'b0000, 0, 0);
      axi_rd(8'h04, 0, v); chk("R8 no lanes", v, 32'h0F0F_F0F0);
   endtask

   task automatic t_unmapped;
      logic [31:0] v;
      axi_wr(8'h3C, 32'hDEAD_BEEF, 4'hF, 0, 0);
      axi_wr(8'h54, 32'hDEAD_BEEF, 4'hF, 1, 0);
      axi_wr(8'h00, 32'hDEAD_BEEF, 4'hF, 2, 0);
      chk("R10 drop unchanged", drop_ratio, 32'h11BB_33DD);
      chk("R10 coef b unchanged", 32'(coef_b), 32'h3FFF);
      chk("R10 corr unchanged", 32'(corr_en), 32'b10);
      axi_rd(8'h00, 0, v); chk("R2 version after write", v, 32'h0002_0100);
      axi_rd(8'h08, 0, v); chk("R10 unmapped read 0x08", v, 32'd0);
      axi_rd(8'h54, 0, v); chk("R10 unmapped read 0x54", v, 32'd0);
   endtask

   task automatic t_backpressure;
      logic [31:0] v;
      axi_wr(8'h04, 32'h5555_AAAA, 4'hF, 0, 4);
      chk("R11 bvalid cleared", 32'(bvalid), 32'd0);
      axi_rd(8'h04, 4, v); chk("R11 read after stall", v, 32'h5555_AAAA);
      chk("R11 rvalid cleared", 32'(rvalid), 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_scratch();
      t_ratio();
      t_codes();
      t_config();
      t_coefs();
      t_strobes();
      t_unmapped();
      t_backpressure();
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL R11 watchdog: actual hung expected done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule